// File: doc/BRIEF.md
# Bit-Addressable GPIO Bank with Interrupts

This block controls a bank of general-purpose pins through a small register bus with a write strobe, an address and write data. Reads are combinational and have no side effects. Software chooses, per pin, whether the pad is driven. Output levels can be loaded as a whole word. They can also be changed per bit through set, clear and toggle addresses, where only the bits written as one are touched. Interrupt enables change per bit in the same way, through a set address and a clear address.

Each pin has an input-enable bit that gates its input buffer. Enabled inputs pass through a two-flop synchroniser. The synchronised level can be read back, and it feeds a per-pin detector. That detector is either level-sensitive or edge-sensitive, and an edge-sensitive pin watches either the rising edge only or both edges. Edge events latch into flags that software clears by writing ones. A single interrupt output combines all enabled pending conditions.

Register addresses: 0 direction, 1 input enable, 2 output data, 3 output set, 4 output clear, 5 output toggle, 6 sensed level, 7 enable set (reads back the enables), 8 enable clear, 9 sensitivity, 10 edge polarity, 11 edge flags.

Top module: `pin_bank_ctrl`

## Requirements
- R1: After reset every register reads zero, `pad_oe_o` and `pad_out_o` are all zero and `irq_o` is low.
- R2: A write to address 0 loads the direction word. In the following cycle `pad_oe_o` equals it (1 = output), and a read of address 0 returns it.
- R3: A write to address 2 loads the whole output word. `pad_out_o` shows it one cycle later, and a read of address 2 returns it.
- R4: Writes to addresses 3, 4 and 5 respectively set, clear and invert only the output bits written as one. Other bits keep their level. Without a write the outputs do not change.
- R5: A read of address 6 returns each pad level after two clock edges of synchronisation, ANDed with the input-enable word at address 1. A disabled pin reads zero.
- R6: A write to address 7 sets the interrupt-enable bits written as one, and a write to address 8 clears them. Zero bits have no effect. A read of address 7 returns the enable word.
- R7: Address 9 selects, per pin, level (0) or edge (1) sensitivity. Address 10 selects, per edge pin, rising edge only (0) or both edges (1). A matching change in the synchronised level sets that pin's flag at address 11 one clock edge after the change becomes readable at address 6.
- R8: A write to address 11 clears only the flags written as one. An edge detected in the same cycle as its clear leaves the flag set.
- R9: `irq_o` is high exactly when, for some pin, the enable is set and either its flag is set or the pin is level-sensitive with its sensed level high.
- R10: A pin whose input enable is zero never sets its flag and never raises a level interrupt. This holds also at the moment it is disabled.
- R11: Reads of addresses 3, 4, 5, 8 and 12 to 15 return zero. Writes to addresses 12 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | N_PINS | Write data |
| bus_rdata_o | output | N_PINS | Read data, combinational from address |
| pad_in_i | input | N_PINS | Pad input levels, asynchronous |
| pad_out_o | output | N_PINS | Pad output levels |
| pad_oe_o | output | N_PINS | Pad output enables |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions take the bus inputs to be defined and steady at every sampling edge. Writes are judged one edge after the strobe, and pad inputs may change in any cycle. The checker treats a newly raised edge flag as valid only if that pin was enabled in the cycle before. The bench drives every input with known values one nanosecond after the rising edge, so the bus and the pads are stable at each edge. The pads toggle freely across the random phase, including while input enables and sensitivities are rewritten.

// File: rtl/pbk_pkg.sv
package pbk_pkg;
  localparam int unsigned REG_AW = 4;
  typedef logic [REG_AW-1:0] reg_addr_t;

  localparam reg_addr_t A_DIR     = 4'd0;
  localparam reg_addr_t A_INEN    = 4'd1;
  localparam reg_addr_t A_DATA    = 4'd2;
  localparam reg_addr_t A_SET     = 4'd3;
  localparam reg_addr_t A_CLR     = 4'd4;
  localparam reg_addr_t A_TGL     = 4'd5;
  localparam reg_addr_t A_LEVEL   = 4'd6;
  localparam reg_addr_t A_IEN_SET = 4'd7;
  localparam reg_addr_t A_IEN_CLR = 4'd8;
  localparam reg_addr_t A_SENSE   = 4'd9;
  localparam reg_addr_t A_BOTH    = 4'd10;
  localparam reg_addr_t A_FLAG    = 4'd11;
endpackage

// File: rtl/pbk_sync.sv
module pbk_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pbk_edge.sv
module pbk_edge #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] edge_mode_i,
  input  logic [W-1:0] both_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  for (genvar g = 0; g < W; g++) begin : g_pin
    logic prev_q, flag_q;
    logic rise, fall, hit;

    // prev tracks the raw level so re-enabling a pin does not fake an edge
    assign rise = en_i[g] &  lvl_i[g] & ~prev_q;
    assign fall = en_i[g] & ~lvl_i[g] &  prev_q;
    assign hit  = edge_mode_i[g] & (rise | (both_i[g] & fall));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        flag_q <= 1'b0;
      end else begin
        prev_q <= lvl_i[g];
        flag_q <= hit | (flag_q & ~clr_i[g]);
      end
    end

    assign flag_o[g] = flag_q;
  end
endmodule

// File: rtl/pbk_regs.sv
module pbk_regs import pbk_pkg::*; #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  reg_addr_t    addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] inen_o,
  output logic [W-1:0] out_o,
  output logic [W-1:0] ien_o,
  output logic [W-1:0] sense_o,
  output logic [W-1:0] both_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o   <= '0;
      inen_o  <= '0;
      out_o   <= '0;
      ien_o   <= '0;
      sense_o <= '0;
      both_o  <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        A_DIR:     dir_o   <= wdata_i;
        A_INEN:    inen_o  <= wdata_i;
        A_DATA:    out_o   <= wdata_i;
        A_SET:     out_o   <= out_o | wdata_i;
        A_CLR:     out_o   <= out_o & ~wdata_i;
        A_TGL:     out_o   <= out_o ^ wdata_i;
        A_IEN_SET: ien_o   <= ien_o | wdata_i;
        A_IEN_CLR: ien_o   <= ien_o & ~wdata_i;
        A_SENSE:   sense_o <= wdata_i;
        A_BOTH:    both_o  <= wdata_i;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl import pbk_pkg::*; #(
  parameter int unsigned N_PINS      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [N_PINS-1:0] bus_wdata_i,
  output logic [N_PINS-1:0] bus_rdata_o,
  input  logic [N_PINS-1:0] pad_in_i,
  output logic [N_PINS-1:0] pad_out_o,
  output logic [N_PINS-1:0] pad_oe_o,
  output logic              irq_o
);
  logic [N_PINS-1:0] dir_q, inen_q, out_q, ien_q, sense_q, both_q;
  logic [N_PINS-1:0] sync_lvl, sensed, flag_q, flag_clr, pending;

  pbk_regs #(.W(N_PINS)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .dir_o   (dir_q),
    .inen_o  (inen_q),
    .out_o   (out_q),
    .ien_o   (ien_q),
    .sense_o (sense_q),
    .both_o  (both_q)
  );

  pbk_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (sync_lvl)
  );

  assign flag_clr = (bus_we_i && bus_addr_i == A_FLAG) ? bus_wdata_i : '0;

  pbk_edge #(.W(N_PINS)) i_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lvl_i       (sync_lvl),
    .en_i        (inen_q),
    .edge_mode_i (sense_q),
    .both_i      (both_q),
    .clr_i       (flag_clr),
    .flag_o      (flag_q)
  );

  assign sensed    = sync_lvl & inen_q;
  assign pending   = flag_q | (~sense_q & sensed);
  assign irq_o     = |(ien_q & pending);
  assign pad_out_o = out_q;
  assign pad_oe_o  = dir_q;

  always_comb begin
    unique case (bus_addr_i)
      A_DIR:     bus_rdata_o = dir_q;
      A_INEN:    bus_rdata_o = inen_q;
      A_DATA:    bus_rdata_o = out_q;
      A_LEVEL:   bus_rdata_o = sensed;
      A_IEN_SET: bus_rdata_o = ien_q;
      A_SENSE:   bus_rdata_o = sense_q;
      A_BOTH:    bus_rdata_o = both_q;
      A_FLAG:    bus_rdata_o = flag_q;
      default:   bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pbk_checker.sv
module pbk_checker import pbk_pkg::*; #(
  parameter int unsigned N_PINS = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic [REG_AW-1:0] bus_addr_i,
  input logic [N_PINS-1:0] bus_wdata_i,
  input logic [N_PINS-1:0] bus_rdata_o,
  input logic [N_PINS-1:0] pad_out_o,
  input logic [N_PINS-1:0] pad_oe_o,
  input logic              irq_o,
  input logic [N_PINS-1:0] ien_q,
  input logic [N_PINS-1:0] flag_q,
  input logic [N_PINS-1:0] inen_q
);
  AST_DIR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == A_DIR) |=> pad_oe_o == $past(bus_wdata_i)); // R2

  AST_DATA_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == A_DATA) |=> pad_out_o == $past(bus_wdata_i)); // R3

  AST_OUT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == A_SET) |=> pad_out_o == ($past(pad_out_o) | $past(bus_wdata_i))); // R4

  AST_OUT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == A_CLR) |=> pad_out_o == ($past(pad_out_o) & ~$past(bus_wdata_i))); // R4

  AST_OUT_TGL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == A_TGL) |=> pad_out_o == ($past(pad_out_o) ^ $past(bus_wdata_i))); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_we_i |=> $stable(pad_out_o) && $stable(pad_oe_o)); // R4

  AST_LEVEL_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == A_LEVEL) |-> (bus_rdata_o & ~inen_q) == '0); // R5

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == '0) |-> !irq_o); // R9

  AST_FLAG_NEEDS_INEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_q & ~$past(flag_q)) & ~$past(inen_q)) == '0); // R10
endmodule

bind pin_bank_ctrl pbk_checker #(.N_PINS(N_PINS)) i_pbk_checker (.*);

// File: tb/test_pin_bank_ctrl.sv
module test_pin_bank_ctrl;
  import pbk_pkg::*;
  localparam int N = 16;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic       we = 1'b0;
  reg_addr_t  addr = '0;
  logic [N-1:0] wdata = '0, pad_in = '0;
  logic [N-1:0] rdata, pad_out, pad_oe;
  logic irq;

  pin_bank_ctrl #(.N_PINS(N)) i_pin_bank_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0;

  task automatic check(string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference
  logic [N-1:0] m_dir, m_inen, m_out, m_ien, m_sense, m_both, m_flag;
  logic [N-1:0] hist[$];

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      {m_dir, m_inen, m_out, m_ien, m_sense, m_both, m_flag} = '0;
      hist = '{'0, '0, '0};
    end else begin
      logic [N-1:0] s, p, up, dn, ev, clr;
      s   = hist[1];
      p   = hist[2];
      up  = m_inen & s & ~p;
      dn  = m_inen & ~s & p;
      ev  = m_sense & (up | (m_both & dn));
      clr = (we && addr == A_FLAG) ? wdata : '0;
      m_flag = ev | (m_flag & ~clr);
      if (we) begin
        case (addr)
          A_DIR:     m_dir   = wdata;
          A_INEN:    m_inen  = wdata;
          A_DATA:    m_out   = wdata;
          A_SET:     m_out   = m_out | wdata;
          A_CLR:     m_out   = m_out & ~wdata;
          A_TGL:     m_out   = m_out ^ wdata;
          A_IEN_SET: m_ien   = m_ien | wdata;
          A_IEN_CLR: m_ien   = m_ien & ~wdata;
          A_SENSE:   m_sense = wdata;
          A_BOTH:    m_both  = wdata;
          default:   ;
        endcase
      end
      hist.push_front(pad_in);
      void'(hist.pop_back());
    end
  end

  function automatic logic [N-1:0] m_rdata(reg_addr_t a);
    case (a)
      A_DIR:     return m_dir;
      A_INEN:    return m_inen;
      A_DATA:    return m_out;
      A_LEVEL:   return hist[1] & m_inen;
      A_IEN_SET: return m_ien;
      A_SENSE:   return m_sense;
      A_BOTH:    return m_both;
      A_FLAG:    return m_flag;
      default:   return '0;
    endcase
  endfunction

  function automatic string req_of(reg_addr_t a);
    case (a)
      A_DIR:             return "R2";
      A_DATA:            return "R3";
      A_INEN, A_LEVEL:   return "R5";
      A_IEN_SET:         return "R6";
      A_SENSE, A_BOTH:   return "R7";
      A_FLAG:            return "R8";
      default:           return "R11";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_ni) begin
      logic m_irq;
      m_irq = |(m_ien & (m_flag | (~m_sense & hist[1] & m_inen)));
      check("R2", "pad_oe", pad_oe, m_dir);
      check("R4", "pad_out", pad_out, m_out);
      check("R9", "irq", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, m_irq});
      check(req_of(addr), "rdata", rdata, m_rdata(addr));
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(reg_addr_t a, logic [N-1:0] d);
    we = 1'b1; addr = a; wdata = d;
    cyc();
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(reg_addr_t a, logic [N-1:0] exp, string req);
    addr = a;
    @(negedge clk);
    check(req, "read", rdata, exp);
    cyc();
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "pad_oe", pad_oe, '0);
    check("R1", "pad_out", pad_out, '0);
    check("R1", "irq", {{(N-1){1'b0}}, irq}, '0);
    for (int a = 0; a < 16; a++) begin
      addr = reg_addr_t'(a);
      #0.5;
      check("R1", "reset read", rdata, '0);
    end
    @(posedge clk); #1; rst_ni = 1'b1;
    cyc();

    wr(A_DIR, 16'h00FF);
    @(negedge clk); check("R2", "oe after write", pad_oe, 16'h00FF); cyc();
    wr(A_DATA, 16'h1234);
    rd_chk(A_DATA, 16'h1234, "R3");
    wr(A_SET, 16'h8001);
    rd_chk(A_DATA, 16'h9235, "R4");
    wr(A_CLR, 16'h0204);
    rd_chk(A_DATA, 16'h9031, "R4");
    wr(A_TGL, 16'hFFFF);
    @(negedge clk); check("R4", "toggle", pad_out, 16'h6FCE); cyc();
    rd_chk(A_SET, '0, "R11");
    wr(reg_addr_t'(12), 16'hFFFF);
    rd_chk(reg_addr_t'(12), '0, "R11");
    rd_chk(A_DATA, 16'h6FCE, "R11");

    pad_in = 16'hA5A5;
    cyc(4);
    rd_chk(A_LEVEL, '0, "R5");
    wr(A_INEN, 16'h00FF);
    cyc(3);
    rd_chk(A_LEVEL, 16'h00A5, "R5");

    wr(A_IEN_SET, 16'h0003);
    wr(A_IEN_SET, 16'h0100);
    rd_chk(A_IEN_SET, 16'h0103, "R6");
    wr(A_IEN_CLR, 16'h0001);
    rd_chk(A_IEN_SET, 16'h0102, "R6");
    @(negedge clk); check("R9", "irq idle", {{(N-1){1'b0}}, irq}, '0); cyc();
    pad_in = 16'hA5A7;
    cyc(3);
    @(negedge clk); check("R9", "level irq", {{(N-1){1'b0}}, irq}, 16'h0001); cyc();

    wr(A_SENSE, 16'h0002);
    cyc(2);
    rd_chk(A_FLAG, '0, "R7");
    pad_in = 16'hA5A5; cyc(4);
    rd_chk(A_FLAG, '0, "R7");
    pad_in = 16'hA5A7; cyc(4);
    rd_chk(A_FLAG, 16'h0002, "R7");
    @(negedge clk); check("R9", "edge irq", {{(N-1){1'b0}}, irq}, 16'h0001); cyc();
    wr(A_FLAG, 16'h0001);
    rd_chk(A_FLAG, 16'h0002, "R8");
    wr(A_FLAG, 16'h0002);
    rd_chk(A_FLAG, '0, "R8");
    wr(A_BOTH, 16'h0002);
    pad_in = 16'hA5A5; cyc(4);
    rd_chk(A_FLAG, 16'h0002, "R7");
    wr(A_FLAG, 16'h0002);

    // R10: disabling an input while high must not flag the drop
    pad_in = 16'hA5A7; cyc(4);
    wr(A_FLAG, 16'hFFFF);
    wr(A_INEN, 16'h00FD);
    cyc(2);
    pad_in = 16'hA5A5; cyc(4);
    rd_chk(A_FLAG, '0, "R10");
    rd_chk(A_LEVEL, 16'h00A5, "R10");

    // random phase, compared every cycle against the reference
    void'($urandom(32'd7));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(3) == 0) pad_in = pad_in ^ (16'h1 << $urandom_range(N - 1));
      we    = ($urandom_range(2) == 0);
      addr  = reg_addr_t'($urandom_range(15));
      wdata = N'($urandom);
      cyc();
    end
    we = 1'b0;
    cyc(2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule